// File: doc/BRIEF.md
# Message Bus Target Receiver

This block is the receiving side of a device attached to a 32-bit synchronous message bus. An initiator frames each transfer with an active-low envelope. Between two messages the envelope goes high. The first word the initiator marks ready inside a new envelope is the header. The block compares the destination field of the header with its own configured identity. A destination of all ones is a broadcast and matches every device. A message that does not match leaves no trace on the outputs.

For a matched message, the block passes each word the initiator marks ready to a simple output stream, one cycle later. The header is marked as the start of the message. A data message ends with a receive-status word that the initiator strobes with an active-low end-of-frame line. The block marks that word and discards any later words. A command message ignores the end-of-frame line. When the envelope is released, the block gives a one-cycle end pulse with a truncation flag.

When a ready word of a matched message arrives while the downstream buffer reports full, the block does not emit the word. It pulses its active-low abort output for one cycle and drops the rest of the message.

Top module: `msg_target_rx`

## Requirements
- R1: After reset, o_valid, o_sop, o_eof, o_end and o_trunc are low and tabt_n is high.
- R2: A message starts only at the first cycle of low env_n after env_n was high. The header is the first word with irdy high in that envelope. It matches when bits [31:24] equal own_id or equal 8'hFF. A matched header is emitted with o_sop high.
- R3: A message whose header does not match produces no o_valid, no o_end and no abort for its whole envelope.
- R4: For a matched message, every word sampled with env_n low and irdy high appears on o_data with o_valid high on the following cycle, in order. Cycles with irdy low emit nothing.
- R5: For a data message (header bit 23 = 1), the ready word sampled with eof_n low is emitted with o_eof high. Later words in the same envelope are discarded.
- R6: For a command message (header bit 23 = 0), eof_n has no effect. Every ready word is emitted with o_eof low.
- R7: For a matched message, o_end pulses for one cycle on the cycle after env_n is first sampled high. For a command message, or a data message whose status word was seen, o_trunc is low with it.
- R8: A matched data message whose envelope ends before a status word was accepted ends with o_trunc high on its o_end cycle.
- R9: A ready word of a matched message sampled with sink_full high is not emitted. tabt_n is low for exactly the next cycle. All remaining words of the envelope are dropped, and o_end comes with o_trunc high.
- R10: While env_n stays low after a status word or an abort, further ready words, including ones that look like a matching header, emit nothing.
- R11: When the status word and sink_full fall in the same cycle, the abort takes precedence: o_eof stays low, the word is dropped and the message ends truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 32 | Bus data word |
| env_n | input | 1 | Message envelope, active low |
| irdy | input | 1 | Initiator ready, enables word capture |
| eof_n | input | 1 | End-of-frame strobe with the status word, active low |
| sink_full | input | 1 | Downstream buffer cannot take a word |
| own_id | input | 8 | Identity of this target |
| tabt_n | output | 1 | Target abort, active low, one-cycle pulse |
| o_valid | output | 1 | Output word valid |
| o_data | output | 32 | Output word |
| o_sop | output | 1 | Output word is the header |
| o_eof | output | 1 | Output word is the receive-status word |
| o_end | output | 1 | Message ended, one-cycle pulse |
| o_trunc | output | 1 | With o_end: the message is incomplete |

## Verification
The status-word strobe and a full downstream buffer can land on the same ready word. That cycle decides between a clean end of frame and an abort. A directed case sets eof_n low and sink_full high together. It passes when the abort pulse appears, o_eof stays low, no word is emitted and the envelope release reports truncation. Random traffic with sparse sink_full also makes the two coincide at times. A bench model predicts each cycle of the outputs, so those cases are judged the same way.

// File: rtl/msg_target_rx.sv
module msg_target_rx #(
  parameter int DW       = 32,
  parameter int IDW      = 8,
  parameter int DST_LSB  = 24,
  parameter int KIND_BIT = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_d,
  input  logic          env_n,
  input  logic          irdy,
  input  logic          eof_n,
  input  logic          sink_full,
  input  logic [IDW-1:0] own_id,
  output logic          tabt_n,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic          o_sop,
  output logic          o_eof,
  output logic          o_end,
  output logic          o_trunc
);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RECV, S_DROP, S_SKIP} st_t;

  st_t  st;
  logic is_data, got_eof, aborted;

  wire            take  = !env_n && irdy;
  wire [IDW-1:0]  dst   = bus_d[DST_LSB +: IDW];
  wire            hit   = (dst == own_id) || (dst == {IDW{1'b1}});
  wire            owned = (st == S_RECV) || (st == S_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_data <= 1'b0;
      got_eof <= 1'b0;
      aborted <= 1'b0;
      tabt_n  <= 1'b1;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sop   <= 1'b0;
      o_eof   <= 1'b0;
      o_end   <= 1'b0;
      o_trunc <= 1'b0;
    end else begin
      tabt_n  <= 1'b1;
      o_valid <= 1'b0;
      o_sop   <= 1'b0;
      o_eof   <= 1'b0;
      o_end   <= 1'b0;
      o_trunc <= 1'b0;
      if (env_n) begin
        if (owned) begin
          o_end   <= 1'b1;
          o_trunc <= aborted || (is_data && !got_eof);
        end
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE, S_HDR: begin
            if (!irdy) st <= S_HDR;
            else if (!hit) st <= S_SKIP;
            else begin
              is_data <= bus_d[KIND_BIT];
              got_eof <= 1'b0;
              if (sink_full) begin
                aborted <= 1'b1;
                tabt_n  <= 1'b0;
                st      <= S_DROP;
              end else begin
                aborted <= 1'b0;
                o_valid <= 1'b1;
                o_sop   <= 1'b1;
                o_data  <= bus_d;
                st      <= S_RECV;
              end
            end
          end
          S_RECV: begin
            if (take) begin
              if (sink_full) begin
                aborted <= 1'b1;
                tabt_n  <= 1'b0;
                st      <= S_DROP;
              end else begin
                o_valid <= 1'b1;
                o_data  <= bus_d;
                if (is_data && !eof_n) begin
                  o_eof   <= 1'b1;
                  got_eof <= 1'b1;
                  st      <= S_DROP;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tabt_n |=> tabt_n);
  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tabt_n |-> !o_valid);
  // R4
  word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(!env_n && irdy));
  // R7
  end_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_end |-> $past(env_n));
  // R5
  eof_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_eof |-> (o_valid && !o_sop));
  // R2
  sop_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_sop |-> (o_data[DST_LSB +: IDW] == $past(own_id) ||
               o_data[DST_LSB +: IDW] == {IDW{1'b1}}));
  // R8
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_trunc |-> o_end);

endmodule

// File: tb/sim_msg_target_rx.sv
module sim_msg_target_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_d = '0;
  logic        env_n = 1'b1, irdy = 1'b0, eof_n = 1'b1, sink_full = 1'b0;
  logic [7:0]  own_id = 8'h5A;
  logic        tabt_n, o_valid, o_sop, o_eof, o_end, o_trunc;
  logic [31:0] o_data;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 header wait, 2 receive, 3 drop, 4 skip
  int m_st = 0;
  bit m_data, m_eof, m_abt;

  always #2 clk = ~clk;

  msg_target_rx u0 (.clk(clk), .rst_n(rst_n), .bus_d(bus_d), .env_n(env_n),
    .irdy(irdy), .eof_n(eof_n), .sink_full(sink_full), .own_id(own_id),
    .tabt_n(tabt_n), .o_valid(o_valid), .o_data(o_data), .o_sop(o_sop),
    .o_eof(o_eof), .o_end(o_end), .o_trunc(o_trunc));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit hits(input logic [31:0] w);
    return (w[31:24] == own_id) || (w[31:24] == 8'hFF);
  endfunction

  task automatic step(input bit e, input bit r, input bit f, input logic [31:0] d, input bit full);
    bit xv = 0, xs = 0, xe = 0, xend = 0, xt = 0, xab = 1;
    env_n = e; irdy = r; eof_n = f; bus_d = d; sink_full = full;
    if (e) begin
      if (m_st == 2 || m_st == 3) begin xend = 1; xt = m_abt | (m_data & !m_eof); end
      m_st = 0;
    end else begin
      case (m_st)
        0, 1: if (!r) m_st = 1;
              else if (!hits(d)) m_st = 4;
              else begin
                m_data = d[23]; m_eof = 0;
                if (full) begin xab = 0; m_abt = 1; m_st = 3; end
                else begin xv = 1; xs = 1; m_abt = 0; m_st = 2; end
              end
        2: if (r) begin
             if (full) begin xab = 0; m_abt = 1; m_st = 3; end
             else begin
               xv = 1;
               if (m_data && !f) begin xe = 1; m_eof = 1; m_st = 3; end
             end
           end
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    chk("R4", "o_valid", 32'(o_valid), 32'(xv));
    if (xv) chk("R4", "o_data", o_data, d);
    chk("R2", "o_sop", 32'(o_sop), 32'(xs));
    chk("R5", "o_eof", 32'(o_eof), 32'(xe));
    chk("R7", "o_end", 32'(o_end), 32'(xend));
    chk("R8", "o_trunc", 32'(o_trunc), 32'(xt));
    chk("R9", "tabt_n", 32'(tabt_n), 32'(xab));
  endtask

  // one message: header, npay words (last is status if st_eof), npost extra words
  task automatic send_msg(input logic [7:0] dst, input bit kind, input int npay, input bit st_eof,
                          input int npost, input int full_at, input int eof_full, input int wait_pct);
    int total = 1 + npay + npost;
    for (int i = 0; i < total; i++) begin
      logic [31:0] w = $urandom;
      bit isst = st_eof && (i == npay) && (npay > 0);
      if (i == 0) w = {dst, kind, w[22:0]};
      while ($urandom_range(99) < wait_pct) step(0, 0, 1'($urandom), $urandom, 1'($urandom));
      step(0, 1, !isst, w, (i == full_at) || (isst && eof_full != 0));
    end
    for (int g = 0; g < 1 + $urandom_range(1); g++) step(1, 1'($urandom), 1'($urandom), $urandom, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "o_valid", 32'(o_valid), 0);
    chk("R1", "o_end", 32'(o_end), 0);
    chk("R1", "tabt_n", 32'(tabt_n), 1);
    chk("R1", "o_sop|o_eof|o_trunc", 32'(o_sop | o_eof | o_trunc), 0);
    rst_n = 1'b1;
    step(1, 0, 1, 0, 0);
    // R2 matched data message with status word, wait states
    send_msg(8'h5A, 1, 4, 1, 0, -1, 0, 30);
    // R2 broadcast
    send_msg(8'hFF, 0, 3, 0, 0, -1, 0, 0);
    // R3 non-matching, with a full buffer that must not trigger abort
    send_msg(8'h33, 1, 3, 1, 0, 2, 0, 20);
    // R6 command message, eof_n low in the middle
    step(0, 1, 1, {8'h5A, 1'b0, 23'h1}, 0);
    step(0, 1, 0, 32'hC0DE_0001, 0);
    step(0, 1, 1, 32'hC0DE_0002, 0);
    step(1, 0, 1, 0, 0);
    // R8 data message truncated
    send_msg(8'h5A, 1, 3, 0, 0, -1, 0, 10);
    // R9 overflow in the middle
    send_msg(8'h5A, 1, 5, 1, 0, 2, 0, 0);
    // R9 overflow on header
    send_msg(8'h5A, 1, 2, 1, 0, 0, 0, 0);
    // R10 words after the status word, one looking like a header
    step(0, 1, 1, {8'h5A, 1'b1, 23'h2}, 0);
    step(0, 1, 0, 32'h5151_0000, 0);
    step(0, 1, 1, {8'h5A, 1'b1, 23'h3}, 0);
    step(0, 1, 1, 32'h7777_7777, 0);
    step(1, 0, 1, 0, 0);
    // R11 status word and full together
    send_msg(8'h5A, 1, 3, 1, 1, -1, 1, 0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(9);
      logic [7:0] dst = (sel < 5) ? own_id : (sel < 7) ? 8'hFF : 8'($urandom_range(0, 200));
      int np = $urandom_range(6);
      int fa = ($urandom_range(9) == 0) ? int'($urandom_range(np)) : -1;
      send_msg(dst, 1'($urandom), np, $urandom_range(3) != 0, $urandom_range(2), fa,
               ($urandom_range(11) == 0), 25);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule